// File: doc/BRIEF.md
# Glitch-Free Clock Select Multiplexer

This block picks one of two free-running clocks and drives a single output clock from it. The select input may move at any phase of either clock. The output never shows a shortened high or low phase because of it. Each clock domain keeps its own enable. The select request is synchronised on the falling edges of that domain's clock. An enable may switch on only once the other domain's enable has gone off, so the old clock is fully stopped before the new one is let through. While neither clock is passed, the output rests at a configurable idle level.

Two configuration inputs fix the start-up behaviour:

- `init_sel` chooses which clock is enabled as soon as reset releases.
- `idle_high` chooses whether the resting level is low or high.

A bypass input gives a plain multiplexer with no handshake. The output then moves to the other clock at once. This is the way out when the clock currently in use has stopped, because the normal handshake would wait forever for that clock's edges.

The select request passes through a falling-edge chain of `SYNC_STAGES` flops in each domain. The number of extra pulses of the old clock therefore depends on the phase of the old clock at the moment the select moves.

Top module: `clksel_glitchfree`

## Requirements
- R1: In normal mode with `idle_high`=0, no high or low phase of `clk_out` is shorter than half the period of the faster input clock. This holds for select changes at any phase, provided successive changes are spaced by at least the handoff time of R4.
- R2: The two internal enables are never on together. Between the old clock stopping and the new one starting, `clk_out` rests at the idle level.
- R3: With `idle_high`=0, `sel` is taken on falling edges of the old clock through `SYNC_STAGES` flops. A change made while the old clock is high lets exactly `SYNC_STAGES`-1 further rising edges of the old clock reach `clk_out`. A change made while it is low lets exactly `SYNC_STAGES` further rising edges through. An enable drops only while `sel` points away from its clock.
- R4: `sel`=0 selects `clk_a` and `sel`=1 selects `clk_b`. After a change, `clk_out` equals the new clock within `SYNC_STAGES`+1 periods of the old clock plus `SYNC_STAGES`+2 periods of the new clock.
- R5: `init_sel` (0 = `clk_a`, 1 = `clk_b`) picks the clock enabled after reset without any handshake. With `sel` equal to it, `clk_out` equals that clock from two of its periods after reset release.
- R6: While `rst_n` is low (asynchronous), both enables are off and `clk_out` equals `idle_high` (0 = rest low, 1 = rest high).
- R7: With `idle_high`=1, enables change only on rising edges of their own clock. `clk_out` rests high when no clock is passed. R1 and R4 hold in this mode as well.
- R8: With `bypass_en`=1, `clk_out` equals `clk_a` when `sel`=0 and `clk_b` when `sel`=1, at once and whatever the enables are.
- R9: In normal mode, if the selected clock stops while it is low and `sel` then changes, `clk_out` stays constant and does not take the new clock. Once the stopped clock runs again, the handoff completes as in R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Input clock chosen when `sel` is 0 |
| clk_b | input | 1 | Input clock chosen when `sel` is 1 |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| sel | input | 1 | Clock choice, may change at any phase |
| init_sel | input | 1 | Clock enabled straight after reset (0 = `clk_a`, 1 = `clk_b`) |
| idle_high | input | 1 | Resting output level when no clock is passed (0 low, 1 high) |
| bypass_en | input | 1 | 1 = plain multiplexer with no handshake |
| clk_out | output | 1 | Glitch-free output clock |

## Verification
The bench builds the block with `SYNC_STAGES` at its default of 2. At that value the extra-pulse counts of R3 are exactly one and two, so each can be counted at the output after a select change placed in the high or the low phase of the old clock. It drives `clk_a` with a 10 ns period and `clk_b` with a 16 ns period. This ratio sets the handoff bound of R4 and the runt threshold of R1. The same settings keep the handoff short enough for many random-phase select toggles in both idle-level modes. The stopped-clock case is driven by holding `clk_a` low, which separates the stuck normal path from the bypass path.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;
    localparam int unsigned NUM_SRC = 2;

    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } clk_src_e;
endpackage

// File: rtl/clksel_branch.sv
`timescale 1ns/1ps
// One clock domain: falling-edge request chain plus rising-edge retime stage.
module clksel_branch
    import clksel_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter clk_src_e    BRANCH_ID   = SRC_A
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic sel,
    input  logic init_sel,
    input  logic idle_high,
    input  logic peer_en,
    output logic en_out
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
    } fall_t;

    typedef struct packed {
        logic en;
    } rise_t;

    fall_t fall_d, fall_q;
    rise_t rise_d, rise_q;

    logic                   want;
    logic                   own_init;
    logic                   en_fall;
    logic [SYNC_STAGES-1:0] chain_rst;

    always_comb begin
        // request only while chosen and the peer is seen off
        want            = (sel == logic'(BRANCH_ID)) && !peer_en;
        own_init        = (init_sel == logic'(BRANCH_ID));
        // earlier stages preloaded, final stage off: first falling edge enables
        chain_rst       = {SYNC_STAGES{own_init}};
        chain_rst[LAST] = 1'b0;
        fall_d.chain    = {fall_q.chain[SYNC_STAGES-2:0], want};
        en_fall         = fall_q.chain[LAST];
        rise_d.en       = en_fall;
        en_out          = idle_high ? rise_q.en : en_fall;
    end

    always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= fall_t'(chain_rst);
        end else begin
            fall_q <= fall_d;
        end
    end

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= '0;
        end else begin
            rise_q <= rise_d;
        end
    end
endmodule

// File: rtl/clksel_combine.sv
`timescale 1ns/1ps
// Output gating: AND/OR for idle low, OR/AND for idle high, plus bypass mux.
module clksel_combine
    import clksel_pkg::*;
(
    input  logic [NUM_SRC-1:0] clk_vec,
    input  logic [NUM_SRC-1:0] en_vec,
    input  logic               idle_high,
    input  logic               bypass_en,
    input  logic               sel,
    output logic               clk_out
);
    logic [NUM_SRC-1:0] pass_lo;
    logic [NUM_SRC-1:0] pass_hi;
    logic               gated;
    logic               direct;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_term
        assign pass_lo[g] = clk_vec[g] & en_vec[g];
        assign pass_hi[g] = clk_vec[g] | ~en_vec[g];
    end

    always_comb begin
        gated   = idle_high ? (&pass_hi) : (|pass_lo);
        direct  = clk_vec[sel];
        clk_out = bypass_en ? direct : gated;
    end
endmodule

// File: rtl/clksel_glitchfree.sv
`timescale 1ns/1ps
module clksel_glitchfree
    import clksel_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst_n,
    input  logic sel,
    input  logic init_sel,
    input  logic idle_high,
    input  logic bypass_en,
    output logic clk_out
);
    logic [NUM_SRC-1:0] clk_vec;
    logic [NUM_SRC-1:0] en_vec;
    logic               en_a;
    logic               en_b;

    assign clk_vec = {clk_b, clk_a};
    assign en_a    = en_vec[0];
    assign en_b    = en_vec[1];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_branch
        clksel_branch #(
            .SYNC_STAGES(SYNC_STAGES),
            .BRANCH_ID  (clk_src_e'(g))
        ) u_branch (
            .clk_in   (clk_vec[g]),
            .rst_n    (rst_n),
            .sel      (sel),
            .init_sel (init_sel),
            .idle_high(idle_high),
            .peer_en  (en_vec[NUM_SRC-1-g]),
            .en_out   (en_vec[g])
        );
    end

    clksel_combine u_combine (
        .clk_vec  (clk_vec),
        .en_vec   (en_vec),
        .idle_high(idle_high),
        .bypass_en(bypass_en),
        .sel      (sel),
        .clk_out  (clk_out)
    );
endmodule

// File: rtl/clksel_glitchfree_chk.sv
`timescale 1ns/1ps
module clksel_glitchfree_chk (
    input logic clk_a,
    input logic clk_b,
    input logic rst_n,
    input logic sel,
    input logic idle_high,
    input logic bypass_en,
    input logic clk_out,
    input logic en_a,
    input logic en_b
);
    // R2
    excl_on_a_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        !(en_a && en_b));

    // R2
    excl_on_b_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        !(en_a && en_b));

    // R3
    drop_a_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        $fell(en_a) |-> sel);

    // R3
    drop_b_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        $fell(en_b) |-> !sel);

    // R6
    reset_idle_chk: assert property (@(posedge clk_b) disable iff (bypass_en)
        !rst_n |-> (clk_out == idle_high));

    // R8
    bypass_a_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        (bypass_en && !sel) |-> !clk_out);
endmodule

bind clksel_glitchfree clksel_glitchfree_chk u_chk (
    .clk_a    (clk_a),
    .clk_b    (clk_b),
    .rst_n    (rst_n),
    .sel      (sel),
    .idle_high(idle_high),
    .bypass_en(bypass_en),
    .clk_out  (clk_out),
    .en_a     (en_a),
    .en_b     (en_b)
);

// File: tb/clksel_glitchfree_bench.sv
`timescale 1ns/1ps
module clksel_glitchfree_bench;
    localparam int CLK_PERIOD = 10;
    localparam int B_PERIOD   = 16;
    localparam real HALF_MIN  = CLK_PERIOD / 2.0;

    // {init_sel, idle_high, target sel}
    localparam logic [2:0] VEC [6] = '{3'b000, 3'b001, 3'b100, 3'b111, 3'b011, 3'b110};

    logic clk_a = 1'b0, clk_b = 1'b0;
    logic run_a = 1'b1;
    logic rst_n = 1'b0, sel = 1'b0, init_sel = 1'b0, idle_high = 1'b0, bypass_en = 1'b0;
    logic clk_out;

    int  n_checks = 0, n_fail = 0;
    int  out_rises = 0, out_edges = 0, runts = 0;
    bit  mon_en = 1'b0, armed = 1'b0, done = 1'b0;
    real last_t = 0.0;

    clksel_glitchfree u_clksel_glitchfree (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .sel(sel),
        .init_sel(init_sel), .idle_high(idle_high), .bypass_en(bypass_en),
        .clk_out(clk_out)
    );

    initial forever begin #(CLK_PERIOD/2); if (run_a) clk_a = ~clk_a; end
    initial forever begin #(B_PERIOD/2); clk_b = ~clk_b; end

    always @(posedge clk_out) out_rises++;
    always @(clk_out) begin
        out_edges++;
        if (mon_en) begin
            if (armed && (($realtime - last_t) < HALF_MIN - 0.01)) runts++;
            armed  = 1'b1;
            last_t = $realtime;
        end else begin
            armed = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic sample_src(output int mis_a, output int mis_b);
        mis_a = 0; mis_b = 0;
        #0.3;
        repeat (30) begin
            if (clk_out !== clk_a) mis_a++;
            if (clk_out !== clk_b) mis_b++;
            #1;
        end
        #0.7;
    endtask

    task automatic do_reset(input logic init, input logic idle);
        mon_en = 1'b0; bypass_en = 1'b0;
        rst_n = 1'b0; init_sel = init; idle_high = idle; sel = init;
        #40;
        chk(clk_out === idle, "R6 idle level in reset", int'(clk_out), int'(idle));
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            report();
            $finish;
        end
    end

    initial begin
        int ma, mb, base, e0, zeros;
        // table walk: reset level, initial source, switch to target
        for (int i = 0; i < 6; i++) begin
            do_reset(VEC[i][2], VEC[i][1]);
            #(2 * (VEC[i][2] ? B_PERIOD : CLK_PERIOD));
            sample_src(ma, mb);
            chk((VEC[i][2] ? mb : ma) == 0, "R5 initial source", VEC[i][2] ? mb : ma, 0);
            sel = VEC[i][0];
            #200;
            sample_src(ma, mb);
            if (VEC[i][1])
                chk((VEC[i][0] ? mb : ma) == 0, "R7 idle-high switch", VEC[i][0] ? mb : ma, 0);
            else
                chk((VEC[i][0] ? mb : ma) == 0, "R4 switch", VEC[i][0] ? mb : ma, 0);
        end

        // R3: change during old clock high phase -> one more pulse; R2 gap at idle
        do_reset(1'b0, 1'b0);
        #100; mon_en = 1'b1;
        @(posedge clk_a); #1;
        base = out_rises; sel = 1'b1;
        #19;
        zeros = 0;
        repeat (8) begin #0.3; if (clk_out === 1'b0) zeros++; #0.7; end
        chk(zeros == 8, "R2 idle gap", zeros, 8);
        chk(out_rises - base == 1, "R3 high-phase change", out_rises - base, 1);
        #200;
        chk(runts == 0, "R1 runt after high-phase change", runts, 0);

        // R3: change during old clock low phase -> two more pulses
        do_reset(1'b0, 1'b0);
        #100; mon_en = 1'b1;
        @(negedge clk_a); #1;
        base = out_rises; sel = 1'b1;
        #27;
        chk(out_rises - base == 2, "R3 low-phase change", out_rises - base, 2);
        #200;
        chk(runts == 0, "R1 runt after low-phase change", runts, 0);

        // R1 / R7: random-phase toggling in both idle modes
        for (int m = 0; m < 2; m++) begin
            do_reset(1'b0, logic'(m));
            #60; mon_en = 1'b1;
            repeat (16) begin
                #(120 + $urandom_range(0, 59));
                sel = ~sel;
            end
            #200; mon_en = 1'b0;
            chk(runts == 0, m ? "R7 runt idle-high" : "R1 runt idle-low", runts, 0);
            sample_src(ma, mb);
            chk((sel ? mb : ma) == 0, "R4 after random toggles", sel ? mb : ma, 0);
        end

        // R9 / R8: stopped clock
        do_reset(1'b0, 1'b0);
        #100;
        @(negedge clk_a); run_a = 1'b0;
        #3; sel = 1'b1;
        #150; e0 = out_edges;
        #100;
        chk(out_edges == e0, "R9 stuck while clock stopped", out_edges - e0, 0);
        bypass_en = 1'b1; #2;
        sample_src(ma, mb);
        chk(mb == 0, "R8 bypass to running clock", mb, 0);
        bypass_en = 1'b0; #2;
        chk(clk_out === 1'b0, "R9 normal path still held", int'(clk_out), 0);
        run_a = 1'b1;
        #200;
        sample_src(ma, mb);
        chk(mb == 0, "R9 handoff after clock resumes", mb, 0);
        bypass_en = 1'b1; sel = 1'b0; #2;
        sample_src(ma, mb);
        chk(ma == 0, "R8 bypass immediate to clk_a", ma, 0);
        #200;
        sel = 1'b1; bypass_en = 1'b0;
        #200;
        sample_src(ma, mb);
        chk(mb == 0, "R4 normal after bypass", mb, 0);

        done = 1'b1;
        report();
        $finish;
    end
endmodule